// File: doc/BRIEF.md
# Triggered Waveform Acquisition Sequencer

This block runs one waveform capture at a time. The host presents a setup word on the configuration inputs and pulses `start`. The setup word holds the mode, the number of samples to take before the trigger, the number to take after it, and the record length. The sequencer latches the setup at that moment and takes charge of the sample clock enable. It counts sample ticks until the pretrigger quota is met. Only then does it arm the external trigger qualifier, and it waits for a qualified trigger gate. After the gate it counts the post-trigger samples and ends the capture.

How a capture ends depends on the mode.

- **Long-record mode** (typically a record of 1024 samples plus a few spare ones for locating the trigger): sampling stops when the post-trigger quota is met, a conversion request is pulsed, and the block waits for the converter to report that it has finished.
- **Short-pipeline mode**: every sample is written as it arrives into a circular store that wraps at the record length. The store address at the trigger is captured, and the capture ends as soon as the post-trigger quota is met.
- **Roll mode**: no trigger is needed. Every sample is forwarded for display, and the capture runs until it is aborted.

Top module: `acq_seq`

## Requirements
- R1: A `start` pulse is accepted only while the block is idle or finished. It latches `cfg_mode`, `cfg_pre`, `cfg_post` and `cfg_len`. One clock later `busy` and `smp_en` are high.
- R2: Mode codes are: 0 long-record, 1 short-pipeline, 2 roll, 3 handled exactly like 0.
- R3: `trig_arm` stays low until `cfg_pre` sample ticks have been counted after the start. It rises one clock after the edge that counts the last of them. With `cfg_pre` = 0 it rises one clock after the start was accepted.
- R4: After the clock on which an armed trigger gate is seen, the capture completes on the clock edge that counts the `cfg_post`-th sample tick, and not before.
- R5: Long-record completion drops `smp_en` and pulses `conv_go` for exactly one clock. The block then waits for `conv_done`, after which `done` is high and `busy` is low.
- R6: In short-pipeline and roll mode, each sample tick taken while sampling gives one `store_we` pulse one clock later. Its `store_addr` starts at 0 after each start and wraps to 0 after `cfg_len`−1; a length of 0 uses the full address range. At the trigger, `trig_addr` takes the address the next store would use. Long-record mode never asserts `store_we`.
- R7: Roll mode never asserts `trig_arm` and ignores `trig_gate`. It gives one `disp_we` pulse per sample tick and stays busy until aborted.
- R8: `done` stays high until the next accepted start. A `start` during a capture has no effect.
- R9: `abort` returns the block to idle from any state on the next clock, clearing `busy`, `done`, `smp_en` and `trig_arm`. It takes priority over `start`.
- R10: With `cfg_post` = 0 the capture completes on the trigger clock itself. A short-pipeline capture is then done one clock later; a long-record capture is then converting.
- R11: After reset, `busy`, `done`, `smp_en`, `trig_arm`, `conv_go`, `store_we` and `disp_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a capture with the current setup |
| abort | input | 1 | Return to idle at once |
| cfg_mode | input | 2 | Capture mode code |
| cfg_pre | input | CW | Pretrigger sample quota |
| cfg_post | input | CW | Post-trigger sample quota |
| cfg_len | input | AW | Circular store length |
| smp_tick | input | 1 | One sample taken this clock |
| trig_gate | input | 1 | Qualified trigger from the qualifier |
| conv_done | input | 1 | Converter finished |
| smp_en | output | 1 | Sample clock enable |
| trig_arm | output | 1 | Enable for the trigger qualifier |
| conv_go | output | 1 | One-clock conversion request |
| store_we | output | 1 | Store one sample |
| store_addr | output | AW | Store address |
| trig_addr | output | AW | Store address captured at the trigger |
| disp_we | output | 1 | Forward one sample for display (roll) |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture finished |

## Verification
Each mode is driven with its own pattern of setup values and sample ticks.

- **Long-record**: a nonzero pretrigger and post-trigger quota shows the exact clocks on which arming and completion happen. A second run with zero quotas separates completion on the trigger clock from completion one tick later.
- **Short-pipeline**: more ticks are given than the record length, so the wrap point and the captured trigger address can be told apart from a pointer that does not wrap. A second run with a zero length exercises the full address range.
- **Roll**: a trigger gate is applied in the middle of the run to show that it is ignored.
- **Control inputs**: start pulses during a capture, and abort pulses given alone and together with start, separate ignored strobes from accepted ones.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [1:0] {
    MODE_LONG   = 2'd0,
    MODE_SHORT  = 2'd1,
    MODE_ROLL   = 2'd2,
    MODE_LONG_B = 2'd3
  } acq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_CONV  = 3'd4,
    ST_DONE  = 3'd5,
    ST_ROLL  = 3'd6
  } acq_state_e;

  function automatic logic is_long(input logic [1:0] m);
    return (m == MODE_LONG) || (m == MODE_LONG_B);
  endfunction
endpackage

// File: rtl/acq_seq_cnt.sv
module acq_seq_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/acq_seq_wptr.sv
module acq_seq_wptr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] ptr,
  output logic          we_q,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] last;
  assign last = len - AW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (wr) begin
      ptr <= (ptr == last) ? '0 : ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      we_q <= wr && !clr;
      if (wr) addr_q <= ptr;
    end
  end
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                abort,
  input  logic                tick,
  input  logic                trig,
  input  logic                conv_done,
  input  logic [1:0]          start_mode,
  input  logic [1:0]          mode,
  input  logic [CW-1:0]       pre,
  input  logic [CW-1:0]       post,
  input  logic [CW-1:0]       cnt,
  output logic                cnt_clr,
  output logic                cnt_inc,
  output logic                load,
  output acq_state_e          st_q,
  output logic                smp_en,
  output logic                trig_arm,
  output logic                conv_go,
  output logic                busy,
  output logic                done
);
  acq_state_e    st_d;
  acq_state_e    fin_st;
  logic [CW-1:0] post_m1;

  assign post_m1 = post - CW'(1);
  assign fin_st  = is_long(mode) ? ST_CONV : ST_DONE;

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    load    = 1'b0;
    if (abort) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            load    = 1'b1;
            cnt_clr = 1'b1;
            st_d    = (start_mode == MODE_ROLL) ? ST_ROLL : ST_FILL;
          end
        end
        ST_FILL: begin
          if (cnt == pre) begin
            st_d    = ST_ARMED;
            cnt_clr = 1'b1;
          end else if (tick) begin
            cnt_inc = 1'b1;
          end
        end
        ST_ARMED: begin
          if (trig) begin
            cnt_clr = 1'b1;
            st_d    = (post == '0) ? fin_st : ST_POST;
          end
        end
        ST_POST: begin
          if (tick) begin
            if (cnt == post_m1) st_d = fin_st;
            else                cnt_inc = 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_done) st_d = ST_DONE;
        end
        ST_ROLL: st_d = ST_ROLL;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      smp_en   <= 1'b0;
      trig_arm <= 1'b0;
      conv_go  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      st_q     <= st_d;
      smp_en   <= (st_d == ST_FILL) || (st_d == ST_ARMED) ||
                  (st_d == ST_POST) || (st_d == ST_ROLL);
      trig_arm <= (st_d == ST_ARMED);
      conv_go  <= (st_d == ST_CONV) && (st_q != ST_CONV);
      busy     <= (st_d != ST_IDLE) && (st_d != ST_DONE);
      done     <= (st_d == ST_DONE);
    end
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_seq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  input  logic [AW-1:0] cfg_len,
  input  logic          smp_tick,
  input  logic          trig_gate,
  input  logic          conv_done,
  output logic          smp_en,
  output logic          trig_arm,
  output logic          conv_go,
  output logic          store_we,
  output logic [AW-1:0] store_addr,
  output logic [AW-1:0] trig_addr,
  output logic          disp_we,
  output logic          busy,
  output logic          done
);
  logic [1:0]    mode_q;
  logic [CW-1:0] pre_q;
  logic [CW-1:0] post_q;
  logic [AW-1:0] len_q;
  logic [CW-1:0] cnt;
  logic          cnt_clr;
  logic          cnt_inc;
  logic          load;
  acq_state_e    st_q;
  logic [AW-1:0] ptr;
  logic          wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'd0;
      pre_q  <= '0;
      post_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      mode_q <= cfg_mode;
      pre_q  <= cfg_pre;
      post_q <= cfg_post;
      len_q  <= cfg_len;
    end
  end

  acq_seq_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .abort      (abort),
    .tick       (smp_tick),
    .trig       (trig_gate),
    .conv_done  (conv_done),
    .start_mode (cfg_mode),
    .mode       (mode_q),
    .pre        (pre_q),
    .post       (post_q),
    .cnt        (cnt),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .load       (load),
    .st_q       (st_q),
    .smp_en     (smp_en),
    .trig_arm   (trig_arm),
    .conv_go    (conv_go),
    .busy       (busy),
    .done       (done)
  );

  acq_seq_cnt #(.CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt)
  );

  assign wr = smp_tick && smp_en && !is_long(mode_q);

  acq_seq_wptr #(.AW(AW)) u_wptr (
    .clk    (clk),
    .rst    (rst),
    .clr    (load),
    .wr     (wr),
    .len    (len_q),
    .ptr    (ptr),
    .we_q   (store_we),
    .addr_q (store_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_addr <= '0;
      disp_we   <= 1'b0;
    end else begin
      if (st_q == ST_ARMED && trig_gate && !abort) trig_addr <= ptr;
      disp_we <= smp_tick && (st_q == ST_ROLL);
    end
  end
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          abort,
  input logic          trig_gate,
  input logic          smp_en,
  input logic          trig_arm,
  input logic          conv_go,
  input logic          busy,
  input logic          done,
  input logic          store_we,
  input logic [AW-1:0] store_addr,
  input logic [AW-1:0] len_q,
  input logic [1:0]    mode_q
);
  p_arm_while_sampling_r3: assert property (@(posedge clk) disable iff (rst)
    trig_arm |-> (smp_en && busy));

  p_conv_single_r5: assert property (@(posedge clk) disable iff (rst)
    conv_go |=> !conv_go);

  p_conv_stopped_r5: assert property (@(posedge clk) disable iff (rst)
    conv_go |-> !smp_en);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start && !abort) |=> done);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !abort) |=> (busy || done));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !done && !smp_en && !trig_arm));

  p_roll_unarmed_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == 2'd2) |-> !trig_arm);

  p_addr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    (store_we && len_q != '0) |-> (store_addr < len_q));

  p_no_long_store_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && (mode_q == 2'd0 || mode_q == 2'd3) && !$rose(busy)) |-> !store_we);
endmodule

bind acq_seq acq_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/acq_seq_test.sv
module acq_seq_test;
  localparam int CW = 16;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [CW-1:0] cfg_pre = '0;
  logic [CW-1:0] cfg_post = '0;
  logic [AW-1:0] cfg_len = '0;
  logic          smp_tick = 1'b0;
  logic          trig_gate = 1'b0;
  logic          conv_done = 1'b0;
  logic          smp_en, trig_arm, conv_go, store_we, disp_we, busy, done;
  logic [AW-1:0] store_addr, trig_addr;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int exp_disp = 0;
  int got_disp = 0;
  bit store_on = 0;
  bit roll_on = 0;
  int model_ptr = 0;
  int model_len = 0;

  always #4 clk = ~clk;

  acq_seq #(.CW(CW), .AW(AW)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    smp_tick = 1'b1;
    if (store_on) begin
      exp_q.push_back(model_ptr);
      if (model_len == 0) model_ptr = (model_ptr + 1) % (1 << AW);
      else model_ptr = (model_ptr == model_len - 1) ? 0 : model_ptr + 1;
    end
    if (roll_on) exp_disp++;
    step(1);
    smp_tick = 1'b0;
  endtask

  task automatic do_start(input int m, input int pre, input int post, input int len);
    cfg_mode = m[1:0];
    cfg_pre  = CW'(pre);
    cfg_post = CW'(post);
    cfg_len  = AW'(len);
    start = 1'b1;
    step(1);
    start = 1'b0;
    model_ptr = 0;
    model_len = len;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    step(1);
    s = 1'b0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops the expected store items as the design writes them
  always @(negedge clk) begin
    if (!rst) begin
      if (store_we) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R6 unexpected store: actual=%0d expected=none", store_addr);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (int'(store_addr) != e) begin
            bad++;
            $display("FAIL R6 store address: actual=%0d expected=%0d", store_addr, e);
          end
        end
      end
      if (disp_we) got_disp++;
    end
  end

  initial begin
    step(200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R11 reset state
    chk(!busy && !done && !smp_en && !trig_arm, "R11", "idle after reset", busy, 0);
    chk(!conv_go && !store_we && !disp_we, "R11", "strobes low", conv_go, 0);

    // long-record: pre 4, post 3
    do_start(0, 4, 3, 1040);
    chk(busy && smp_en, "R1", "busy after start", busy, 1);
    chk(!trig_arm, "R3", "not armed at start", trig_arm, 0);
    repeat (3) pulse_tick();
    chk(!trig_arm, "R3", "not armed after 3 ticks", trig_arm, 0);
    pulse_tick();
    chk(!trig_arm, "R3", "not armed on quota edge", trig_arm, 0);
    step(1);
    chk(trig_arm, "R3", "armed after quota", trig_arm, 1);
    do_start(2, 0, 0, 0);
    chk(trig_arm && busy, "R8", "start ignored while armed", trig_arm, 1);
    pulse(trig_gate);
    chk(!trig_arm && smp_en, "R4", "post counting", trig_arm, 0);
    repeat (2) pulse_tick();
    chk(!conv_go && smp_en, "R4", "not complete after 2 of 3", conv_go, 0);
    pulse_tick();
    chk(conv_go && !smp_en, "R5", "convert requested", conv_go, 1);
    step(1);
    chk(!conv_go, "R5", "convert pulse single", conv_go, 0);
    step(3);
    chk(busy && !done, "R5", "waiting for converter", done, 0);
    pulse(conv_done);
    chk(done && !busy, "R5", "done after convert", done, 1);
    repeat (2) pulse_tick();
    step(3);
    chk(done, "R8", "done held", done, 1);

    // short-pipeline: pre 2, post 0, len 5
    do_start(1, 2, 0, 5);
    chk(busy && !done, "R1", "start accepted from done", busy, 1);
    store_on = 1;
    repeat (7) pulse_tick();
    chk(trig_arm, "R3", "short armed", trig_arm, 1);
    pulse(trig_gate);
    store_on = 0;
    chk(done && !smp_en, "R10", "zero post completes on trigger", done, 1);
    chk(trig_addr == 2, "R6", "trigger address after wrap", trig_addr, 2);
    pulse_tick();
    step(1);
    chk(exp_q.size() == 0, "R6", "stores drained", exp_q.size(), 0);

    // short-pipeline: pre 0, post 3, full address range
    do_start(1, 0, 3, 0);
    store_on = 1;
    step(1);
    chk(trig_arm, "R3", "zero pretrigger arms at once", trig_arm, 1);
    pulse(trig_gate);
    chk(trig_addr == 0, "R6", "trigger address", trig_addr, 0);
    repeat (2) pulse_tick();
    chk(!done && busy, "R4", "short not done after 2", done, 0);
    pulse_tick();
    store_on = 0;
    chk(done && !busy, "R4", "short done after 3", done, 1);
    step(1);

    // roll mode
    do_start(2, 3, 0, 4);
    store_on = 1;
    roll_on = 1;
    chk(busy && smp_en && !trig_arm, "R7", "roll running unarmed", trig_arm, 0);
    repeat (6) pulse_tick();
    pulse(trig_gate);
    chk(busy && !trig_arm && !done, "R7", "trigger ignored in roll", busy, 1);
    chk(got_disp == exp_disp, "R7", "display pulses", got_disp, exp_disp);
    store_on = 0;
    roll_on = 0;
    pulse(abort);
    chk(!busy && !done && !smp_en, "R9", "abort from roll", busy, 0);
    chk(exp_q.size() == 0, "R6", "roll stores drained", exp_q.size(), 0);

    // mode 3 behaves as long-record; abort beats start
    do_start(3, 0, 5, 8);
    step(1);
    chk(trig_arm, "R2", "mode 3 armed", trig_arm, 1);
    repeat (2) pulse_tick();
    abort = 1'b1;
    start = 1'b1;
    step(1);
    abort = 1'b0;
    start = 1'b0;
    chk(!busy && !trig_arm && !smp_en, "R9", "abort wins over start", busy, 0);

    // long-record with zero post: convert on trigger clock
    do_start(0, 0, 0, 8);
    step(1);
    pulse(trig_gate);
    chk(conv_go && !smp_en, "R10", "long zero post converts", conv_go, 1);
    pulse(conv_done);
    chk(done, "R5", "long done", done, 1);
    pulse(abort);
    chk(!done && !busy, "R9", "abort clears done", done, 0);

    step(2);
    chk(exp_q.size() == 0, "R6", "no stray expected stores", exp_q.size(), 0);
    report();
  end
endmodule